// File: doc/BRIEF.md
# Self-starting decade counter

This block is a single-digit synchronous decimal counter held in four flip-flops. Each clock edge with the count enable high moves it one step through the codes 0 to 9. After 9 it returns to 0. The six codes above 9 have no decimal meaning, but they can still appear at power-up or after an upset. Each of them has a fixed next state, so the counter always finds its way back into the decimal cycle and can never lock up outside it.

The next-state logic is built from minimized sum-of-products equations, and those equations decide where the unused codes go. A second, table-driven form of the same function can be chosen with a parameter. A terminal-count flag marks the step where the digit is about to wrap. The reset code is a parameter, with a default of 0000.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next `count_o` is the reset code (0000 by default). Reset takes priority over `cnt_en`.
- R2: With `cnt_en` high and `count_o` a code from 0 to 8, the next `count_o` is the present value plus one.
- R3: With `cnt_en` high and `count_o` equal to 9 (1001), the next `count_o` is 0 (0000).
- R4: With `cnt_en` low and `rst` low, `count_o` keeps its value across the edge.
- R5: On every enabled step, bit 0 of the next `count_o` is the inverse of the present bit 0, for legal and unused codes alike.
- R6: With `cnt_en` high, the unused codes step as follows: 1010 to 1011, 1011 to 0100, 1100 to 1101, 1101 to 0100, 1110 to 1111, and 1111 to 1000.
- R7: From any unused code, at most two enabled edges bring `count_o` into the range 0 to 9. From an odd unused code one edge is enough. No unused code loops back onto itself.
- R8: `tc_o` is high in exactly one case: `count_o` is 1001 and `cnt_en` is high in the same cycle. It is low for every other code, unused codes included.
- R9: Parameter `RESET_CODE` (0 to 15) selects the value loaded by reset. Elaboration rejects values above 15 and unknown `NS_IMPL` values.
- R10: `NS_IMPL` = 0 (equations) and `NS_IMPL` = 1 (table) give the same sequence of `count_o` for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; the state holds while low |
| count_o | output | 4 | Present counter code, binary weighted |
| tc_o | output | 1 | Terminal count: state 1001 with enable high |

## Verification
The state changes one rising edge after an enabled or reset cycle. `tc_o` is combinational and is valid in the same cycle as the enable that qualifies it. The bench drives every input on the falling edge. It checks `tc_o` one time unit after that drive, and it checks `count_o` one time unit after the next rising edge. Each check therefore compares against exactly one register update. Six extra instances, reset into each unused code, are stepped twice with enable high. After each step they are compared with a model in the bench, which shows the exact recovery path and the two-edge bound.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

   localparam int unsigned CODE_W = 4;
   localparam int unsigned NUM_CODES = 1 << CODE_W;
   localparam int unsigned DIGITS = 10;

   typedef logic [CODE_W-1:0] code_t;

   localparam code_t CODE_ZERO = code_t'(0);
   localparam code_t CODE_LAST = code_t'(DIGITS - 1);

   typedef enum int unsigned {
      NS_SOP   = 0,
      NS_TABLE = 1
   } ns_impl_e;

   function automatic logic is_digit(input code_t c);
      return c < code_t'(DIGITS);
   endfunction

endpackage

// File: rtl/bcd_nxt_logic.sv
module bcd_nxt_logic
   import bcd_ctr_pkg::*;
#(
   parameter int unsigned NS_IMPL = NS_SOP
) (
   input  code_t cur_i,
   output code_t nxt_o
);

   logic s3, s2, s1, s0;

   assign s3 = cur_i[3];
   assign s2 = cur_i[2];
   assign s1 = cur_i[1];
   assign s0 = cur_i[0];

   generate
      if (NS_IMPL == NS_SOP) begin : g_sop
         // Two-level equations; unused codes follow wherever they lead.
         logic n3, n2, n1, n0;
         assign n3 = (s3 & ~s0) | (s2 & s1 & s0);
         assign n2 = (s2 & ~s0) | (s2 & ~s1) | (~s2 & s1 & s0);
         assign n1 = (s1 & ~s0) | (~s3 & ~s1 & s0);
         assign n0 = ~s0;
         assign nxt_o = {n3, n2, n1, n0};
      end else begin : g_table
         code_t tbl_nxt;
         always_comb begin
            if (cur_i < CODE_LAST) begin
               tbl_nxt = cur_i + code_t'(1);
            end else begin
               unique case (cur_i)
                  4'b1001: tbl_nxt = CODE_ZERO;
                  4'b1010: tbl_nxt = 4'b1011;
                  4'b1011: tbl_nxt = 4'b0100;
                  4'b1100: tbl_nxt = 4'b1101;
                  4'b1101: tbl_nxt = 4'b0100;
                  4'b1110: tbl_nxt = 4'b1111;
                  4'b1111: tbl_nxt = 4'b1000;
                  default: tbl_nxt = CODE_ZERO;
               endcase
            end
         end
         assign nxt_o = tbl_nxt;
      end
   endgenerate

endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
   import bcd_ctr_pkg::*;
#(
   parameter code_t RST_VAL = CODE_ZERO
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  en_i,
   input  code_t d_i,
   output code_t q_o
);

   code_t state_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RST_VAL;
      end else if (en_i) begin
         state_q <= d_i;
      end
   end

   assign q_o = state_q;

endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect
   import bcd_ctr_pkg::*;
#(
   parameter code_t TERM_VAL = CODE_LAST
) (
   input  code_t cur_i,
   input  logic  en_i,
   output logic  tc_o
);

   assign tc_o = en_i & (cur_i == TERM_VAL);

endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
   import bcd_ctr_pkg::*;
#(
   parameter int unsigned RESET_CODE = 0,
   parameter int unsigned NS_IMPL    = NS_SOP
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cnt_en,
   output logic [3:0] count_o,
   output logic       tc_o
);

   localparam code_t RST_VAL = code_t'(RESET_CODE);

   // R9: parameter legality at elaboration
   if (RESET_CODE >= NUM_CODES) begin : g_bad_reset
      $error("RESET_CODE %0d does not fit in %0d bits", RESET_CODE, CODE_W);
   end
   if (NS_IMPL != NS_SOP && NS_IMPL != NS_TABLE) begin : g_bad_impl
      $error("NS_IMPL %0d is not a known variant", NS_IMPL);
   end

   code_t cur_code;
   code_t nxt_code;

   bcd_nxt_logic #(
      .NS_IMPL (NS_IMPL)
   ) u_nxt (
      .cur_i (cur_code),
      .nxt_o (nxt_code)
   );

   bcd_state_reg #(
      .RST_VAL (RST_VAL)
   ) u_reg (
      .clk  (clk),
      .rst  (rst),
      .en_i (cnt_en),
      .d_i  (nxt_code),
      .q_o  (cur_code)
   );

   bcd_term_detect #(
      .TERM_VAL (CODE_LAST)
   ) u_tc (
      .cur_i (cur_code),
      .en_i  (cnt_en),
      .tc_o  (tc_o)
   );

   assign count_o = cur_code;

endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk #(
   parameter int unsigned RESET_CODE = 0
) (
   input logic       clk,
   input logic       rst,
   input logic       cnt_en,
   input logic [3:0] count_o,
   input logic       tc_o
);

   localparam logic [3:0] RST_V = 4'(RESET_CODE);

   // R1
   a_r1_reset_load: assert property (@(posedge clk)
      rst |=> count_o == RST_V);

   // R2
   a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && count_o < 4'd9) |=> count_o == $past(count_o) + 4'd1);

   // R3
   a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && count_o == 4'd9) |=> count_o == 4'd0);

   // R4
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(count_o));

   // R5
   a_r5_lsb_toggle: assert property (@(posedge clk) disable iff (rst)
      cnt_en |=> count_o[0] != $past(count_o[0]));

   // R7: an unused code never stays unused for more than one more step
   a_r7_first_step: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && count_o > 4'd9) |=> (count_o < 4'd10 || count_o[0]));
   a_r7_odd_exit: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && count_o > 4'd9 && count_o[0]) |=> count_o < 4'd10);

   // R8
   a_r8_tc_illegal_low: assert property (@(posedge clk) disable iff (rst)
      (count_o != 4'd9) |-> !tc_o);
   a_r8_tc_needs_en: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |-> !tc_o);

endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(
   .RESET_CODE (RESET_CODE)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .cnt_en  (cnt_en),
   .count_o (count_o),
   .tc_o    (tc_o)
);

// File: tb/bcd_decade_counter_tb_top.sv
module bcd_decade_counter_tb_top;

   localparam int CLK_PERIOD_NS = 10;
   localparam int N_REC = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cnt_en = 1'b0;
   logic rec_en = 1'b0;

   logic [3:0] count_o, alt_count;
   logic       tc_o, alt_tc;
   logic [3:0] rec_cnt [N_REC];
   logic       rec_tc  [N_REC];

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD_NS / 2) clk = ~clk;

   bcd_decade_counter #(.RESET_CODE(0), .NS_IMPL(0)) dut_i (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .count_o(count_o), .tc_o(tc_o));

   bcd_decade_counter #(.RESET_CODE(0), .NS_IMPL(1)) alt_i (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .count_o(alt_count), .tc_o(alt_tc));

   for (genvar g = 0; g < N_REC; g++) begin : g_rec
      bcd_decade_counter #(.RESET_CODE(10 + g), .NS_IMPL(0)) rec_i (
         .clk(clk), .rst(rst), .cnt_en(rec_en),
         .count_o(rec_cnt[g]), .tc_o(rec_tc[g]));
   end

   // Model from the requirements: +1 mod 10 on legal codes, fixed map on unused ones.
   function automatic logic [3:0] model_next(input logic [3:0] c);
      if (c < 4'd10) return (c == 4'd9) ? 4'd0 : c + 4'd1;
      case (c)
         4'd10:   return 4'd11;
         4'd11:   return 4'd4;
         4'd12:   return 4'd13;
         4'd13:   return 4'd4;
         4'd14:   return 4'd15;
         default: return 4'd8;
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(CLK_PERIOD_NS * 5000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [3:0] m;
      logic [3:0] prev;
      logic       en_now;

      // Reset state
      repeat (2) @(posedge clk);
      #1;
      check("R1 reset value", count_o, 4'd0);
      check("R8 tc low in reset", {3'b0, tc_o}, 4'd0);
      for (int g = 0; g < N_REC; g++)
         check("R9 reset code parameter", rec_cnt[g], 4'(10 + g));

      @(negedge clk);
      rst = 1'b0;
      m = 4'd0;

      // Sweep: enable pattern with gaps, several wraps
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         en_now = ((i % 4) != 3) && ((i % 11) != 5);
         cnt_en = en_now;
         #1;
         check("R8 tc flag", {3'b0, tc_o}, {3'b0, (en_now && m == 4'd9)});
         prev = m;
         @(posedge clk);
         #1;
         if (en_now) m = model_next(m);
         if (!en_now)            check("R4 hold", count_o, m);
         else if (prev == 4'd9)  check("R3 wrap", count_o, m);
         else                    check("R2 step", count_o, m);
         check("R5 lsb", {3'b0, count_o[0]}, {3'b0, prev[0] ^ en_now});
         check("R10 variants agree", alt_count, count_o);
      end

      // Reset wins over enable mid-count
      @(negedge clk);
      rst = 1'b1;
      cnt_en = 1'b1;
      @(posedge clk);
      #1;
      check("R1 reset over enable", count_o, 4'd0);
      @(negedge clk);
      rst = 1'b0;
      cnt_en = 1'b0;

      // Recovery from every unused code
      @(negedge clk);
      for (int g = 0; g < N_REC; g++)
         check("R8 tc low on unused", {3'b0, rec_tc[g]}, 4'd0);
      rec_en = 1'b1;
      @(posedge clk);
      #1;
      for (int g = 0; g < N_REC; g++) begin
         check("R6 unused first step", rec_cnt[g], model_next(4'(10 + g)));
         if (((10 + g) % 2) == 1)
            check("R7 odd exits in one", {3'b0, rec_cnt[g] < 4'd10}, 4'd1);
      end
      @(posedge clk);
      #1;
      for (int g = 0; g < N_REC; g++) begin
         check("R6 unused second step", rec_cnt[g], model_next(model_next(4'(10 + g))));
         check("R7 legal within two", {3'b0, rec_cnt[g] < 4'd10}, 4'd1);
      end
      @(negedge clk);
      rec_en = 1'b0;
      for (int g = 0; g < N_REC; g++) begin
         m = model_next(model_next(4'(10 + g)));
         @(posedge clk);
         #1;
         check("R4 hold recovered", rec_cnt[g], m);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule